// File: doc/BRIEF.md
# Branch Target Cache

This block lives in the instruction-fetch stage and redirects a sequential
fetch stream to the remembered target of a simple relative branch. It is
direct-mapped: each of its entries holds the full word address of one branch
and the word address that branch jumped to. The index is taken from fetch
address bits 11 down to 2, which gives 1024 entries by default. The execute
stage trains it through an update port. Every resolved simple branch rewrites
its entry. The entry becomes valid when the branch was taken and invalid when
it was not.

The read is moved two instructions ahead to ease timing. Each accepted fetch
starts a read of the entry for its own address plus 8. That result is compared
two fetches later, when the fetch address has caught up with it. On a match the
block raises `pred_hit` in the same cycle and drives `pred_tgt`. The fetch stage
uses this as a redirect request and as the predicted-taken flag that travels
with the fetched branch, so decode skips its own static guess. One cost of the
lookahead is that the first two fetches after a redirect cannot be predicted. A
redirect from downstream (`flush`) throws away any lookup that would have been
used in its cycle. A build parameter can remove the whole structure.

Top module: `brtgt_cache`

## Requirements
- R1: After reset every entry is invalid, so no fetch produces `pred_hit` until a taken update has been made.
- R2: After a taken update for branch address P with target T, a fetch of P asserts `pred_hit` in that same cycle, with `pred_tgt` equal to T with bits 1:0 forced to zero. The fetch of P must be sequential (`fetch_seq`=1) and at least the third fetch after a redirect.
- R3: A not-taken update for P clears the entry's valid bit, so a later sequential fetch of P gives no `pred_hit`.
- R4: A fetch with `fetch_seq`=0 is never predicted, and neither is the sequential fetch that directly follows it. The second sequential fetch after it is the first that can be predicted.
- R5: The match compares fetch address bits 63:2 with the stored branch address. An entry at the same index (bits 11:2) whose other bits differ never hits. Bits 1:0 of `upd_pc` and `upd_tgt` are ignored.
- R6: `flush` high suppresses `pred_hit` in its cycle and drops the lookups in flight. Stored entries are not affected.
- R7: When an update and a lookahead read hit the same index in one cycle, the read returns the contents from before the update.
- R8: While `fetch_en` is low, `pred_hit` stays low and the lookahead pipeline holds, so stall cycles between fetches do not lose a prediction.
- R9: With `ENABLE`=0, `pred_hit` and `pred_tgt` are constant zero.
- R10: An update to an index that already holds another branch replaces it. The older branch stops hitting and the newer one hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | A fetch of `fetch_pc` is made this cycle |
| fetch_seq | input | 1 | This fetch is the previous fetch address plus 4 |
| fetch_pc | input | ADDR_W | Address being fetched |
| flush | input | 1 | Redirect from decode or execute this cycle |
| upd_en | input | 1 | A resolved simple branch is reported |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_tgt | input | ADDR_W | Target of the resolved branch |
| upd_taken | input | 1 | The resolved branch was taken |
| pred_hit | output | 1 | Redirect request and predicted-taken flag for this fetch |
| pred_tgt | output | ADDR_W | Predicted target, valid with `pred_hit` |

## Verification
The main function is tried with runs that start with a non-sequential fetch and
reach a trained branch on the first, second and third fetch. This separates a
correct two-deep lookahead from one that is too short or too long. Further
patterns pair a trained branch with an alias that shares the index but differs
only in upper bits, with a not-taken retrain, and with a replacement at the same
index. Each of these would show a comparison that is too narrow or a valid bit
that is handled wrongly. Stall gaps, a flush on the matching fetch, and an update
in the same cycle as the read of its index check the hold, discard and
old-data behaviours. A second instance built with the cache removed shows that
the disabled build never predicts.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
    // byte distance between the fetch address and the entry read in the same cycle
    localparam int unsigned AHEAD_BYTES = 8;
    // lowest address bit used by the index and the tag
    localparam int unsigned WORD_LSB    = 2;
endpackage

// File: rtl/brtgt_store.sv
module brtgt_store #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [ADDR_W-3:0]    wr_tag,
    input  logic [ADDR_W-3:0]    wr_tgt,
    input  logic                 wr_vld,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_vld,
    output logic [ADDR_W-3:0]    rd_tag,
    output logic [ADDR_W-3:0]    rd_tgt
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int unsigned TW    = ADDR_W - 2;

    logic [TW-1:0]    tag_mem [DEPTH];
    logic [TW-1:0]    tgt_mem [DEPTH];
    logic [DEPTH-1:0] vld_d, vld_q;

    // valid bits: the only state that needs a reset
    always_comb begin
        vld_d = vld_q;
        if (wr_en) begin
            vld_d[wr_idx] = wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    // address and target arrays carry no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            tgt_mem[wr_idx] <= wr_tgt;
        end
    end

    // read sees the contents before any write at this edge
    assign rd_vld = vld_q[rd_idx];
    assign rd_tag = tag_mem[rd_idx];
    assign rd_tgt = tgt_mem[rd_idx];
endmodule

// File: rtl/brtgt_lookahead.sv
module brtgt_lookahead #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic              fetch_seq,
    input  logic [ADDR_W-3:0] fetch_word,
    input  logic              flush,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_vld,
    input  logic [ADDR_W-3:0] rd_tag,
    input  logic [ADDR_W-3:0] rd_tgt,
    output logic              hit,
    output logic [ADDR_W-3:0] hit_tgt
);
    import brtgt_pkg::*;

    localparam int unsigned TW        = ADDR_W - 2;
    localparam int unsigned AHEAD_WDS = AHEAD_BYTES >> WORD_LSB;

    // stage a: read launched by the latest fetch; stage b: read from the fetch before it
    typedef struct packed {
        logic          a_ok;
        logic          a_vld;
        logic [TW-1:0] a_tag;
        logic [TW-1:0] a_tgt;
        logic          b_ok;
        logic          b_vld;
        logic [TW-1:0] b_tag;
        logic [TW-1:0] b_tgt;
    } pipe_t;

    pipe_t st_d, st_q;

    assign rd_idx = fetch_word[IDX_W-1:0] + IDX_W'(AHEAD_WDS);

    always_comb begin
        st_d    = st_q;
        hit     = fetch_en && fetch_seq && !flush && st_q.b_ok && st_q.b_vld
                  && (st_q.b_tag == fetch_word);
        hit_tgt = st_q.b_tgt;

        if (flush) begin
            st_d.a_ok = 1'b0;
            st_d.b_ok = 1'b0;
        end else if (fetch_en) begin
            st_d.b_ok  = fetch_seq && st_q.a_ok;
            st_d.b_vld = st_q.a_vld;
            st_d.b_tag = st_q.a_tag;
            st_d.b_tgt = st_q.a_tgt;
            st_d.a_ok  = 1'b1;
            st_d.a_vld = rd_vld;
            st_d.a_tag = rd_tag;
            st_d.a_tgt = rd_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 10,
    parameter bit          ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic              fetch_seq,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              flush,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_tgt,
    input  logic              upd_taken,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_tgt
);
    import brtgt_pkg::*;

    localparam int unsigned TW = ADDR_W - WORD_LSB;

    generate
        if (ENABLE) begin : g_on
            logic [IDX_W-1:0] rd_idx;
            logic             rd_vld;
            logic [TW-1:0]    rd_tag;
            logic [TW-1:0]    rd_tgt;
            logic [TW-1:0]    hit_tgt;
            logic             low_bits_unused;

            assign low_bits_unused = ^{fetch_pc[WORD_LSB-1:0], upd_pc[WORD_LSB-1:0],
                                       upd_tgt[WORD_LSB-1:0]};

            brtgt_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (upd_en),
                .wr_idx (upd_pc[WORD_LSB+IDX_W-1:WORD_LSB]),
                .wr_tag (upd_pc[ADDR_W-1:WORD_LSB]),
                .wr_tgt (upd_tgt[ADDR_W-1:WORD_LSB]),
                .wr_vld (upd_taken),
                .rd_idx (rd_idx),
                .rd_vld (rd_vld),
                .rd_tag (rd_tag),
                .rd_tgt (rd_tgt)
            );

            brtgt_lookahead #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ahead (
                .clk        (clk),
                .rst_n      (rst_n),
                .fetch_en   (fetch_en),
                .fetch_seq  (fetch_seq),
                .fetch_word (fetch_pc[ADDR_W-1:WORD_LSB]),
                .flush      (flush),
                .rd_idx     (rd_idx),
                .rd_vld     (rd_vld),
                .rd_tag     (rd_tag),
                .rd_tgt     (rd_tgt),
                .hit        (pred_hit),
                .hit_tgt    (hit_tgt)
            );

            assign pred_tgt = {hit_tgt, {WORD_LSB{1'b0}}};
        end else begin : g_off
            logic all_inputs_unused;
            assign all_inputs_unused = ^{clk, rst_n, fetch_en, fetch_seq, fetch_pc, flush,
                                         upd_en, upd_pc, upd_tgt, upd_taken};
            assign pred_hit = 1'b0;
            assign pred_tgt = '0;
        end
    endgenerate
endmodule

// File: rtl/brtgt_cache_chk.sv
module brtgt_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic fetch_en,
    input logic fetch_seq,
    input logic flush,
    input logic upd_en,
    input logic upd_taken,
    input logic pred_hit
);
    // fetches since the last redirect, saturating at 3
    logic [1:0] run_d, run_q;
    logic       trained_d, trained_q;

    always_comb begin
        run_d     = run_q;
        trained_d = trained_q || (upd_en && upd_taken);
        if (flush) begin
            run_d = 2'd0;
        end else if (fetch_en) begin
            if (!fetch_seq) begin
                run_d = 2'd1;
            end else if (run_q != 2'd3) begin
                run_d = run_q + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 2'd0;
            trained_q <= 1'b0;
        end else begin
            run_q     <= run_d;
            trained_q <= trained_d;
        end
    end

    a_r1_no_hit_untrained: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> trained_q);

    a_r4_third_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> (run_q >= 2'd2));

    a_r6_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !pred_hit);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |-> !pred_hit);
endmodule

bind brtgt_cache brtgt_cache_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_en  (fetch_en),
    .fetch_seq (fetch_seq),
    .flush     (flush),
    .upd_en    (upd_en),
    .upd_taken (upd_taken),
    .pred_hit  (pred_hit)
);

// File: tb/tb_brtgt_cache.sv
module tb_brtgt_cache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0;
    logic        fetch_seq = 1'b0;
    logic [63:0] fetch_pc = '0;
    logic        flush = 1'b0;
    logic        upd_en = 1'b0;
    logic [63:0] upd_pc = '0;
    logic [63:0] upd_tgt = '0;
    logic        upd_taken = 1'b0;
    logic        pred_hit, hit_off;
    logic [63:0] pred_tgt, tgt_off;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brtgt_cache dut (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_seq(fetch_seq),
        .fetch_pc(fetch_pc), .flush(flush), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_tgt(upd_tgt), .upd_taken(upd_taken), .pred_hit(pred_hit), .pred_tgt(pred_tgt)
    );

    brtgt_cache #(.ENABLE(1'b0)) dut_off (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_seq(fetch_seq),
        .fetch_pc(fetch_pc), .flush(flush), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_tgt(upd_tgt), .upd_taken(upd_taken), .pred_hit(hit_off), .pred_tgt(tgt_off)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one fetch cycle; outputs sampled one time unit after the inputs settle
    task automatic do_fetch(input logic [63:0] a, input logic seq, input logic fl,
                            input logic exp_hit, input logic [63:0] exp_tgt, input string req);
        @(negedge clk);
        fetch_en = 1'b1; fetch_pc = a; fetch_seq = seq; flush = fl;
        #1;
        chk(req, {63'd0, pred_hit}, {63'd0, exp_hit});
        if (exp_hit) chk(req, pred_tgt, exp_tgt);
        chk("R9", {63'd0, hit_off} | tgt_off, 64'd0);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        fetch_en = 1'b0; flush = 1'b0;
    endtask

    task automatic train(input logic [63:0] pc, input logic [63:0] tgt, input logic tk);
        @(negedge clk);
        fetch_en = 1'b0; flush = 1'b0;
        upd_en = 1'b1; upd_pc = pc; upd_tgt = tgt; upd_taken = tk;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1", {63'd0, pred_hit}, 64'd0);
        do_fetch(64'h1000, 1'b0, 1'b0, 1'b0, 64'd0, "R1");
        do_fetch(64'h1004, 1'b1, 1'b0, 1'b0, 64'd0, "R1");
        do_fetch(64'h1008, 1'b1, 1'b0, 1'b0, 64'd0, "R1");
        do_fetch(64'h100C, 1'b1, 1'b0, 1'b0, 64'd0, "R1");
        idle();
    endtask

    task automatic t_basic_hit();
        train(64'h1008, 64'h2000, 1'b1);
        do_fetch(64'h1000, 1'b0, 1'b0, 1'b0, 64'd0, "R2");
        do_fetch(64'h1004, 1'b1, 1'b0, 1'b0, 64'd0, "R2");
        do_fetch(64'h1008, 1'b1, 1'b0, 1'b1, 64'h2000, "R2");
        do_fetch(64'h2000, 1'b0, 1'b0, 1'b0, 64'd0, "R2");
        idle();
    endtask

    task automatic t_not_taken();
        train(64'h1008, 64'h2000, 1'b0);
        do_fetch(64'h1000, 1'b0, 1'b0, 1'b0, 64'd0, "R3");
        do_fetch(64'h1004, 1'b1, 1'b0, 1'b0, 64'd0, "R3");
        do_fetch(64'h1008, 1'b1, 1'b0, 1'b0, 64'd0, "R3");
        idle();
    endtask

    task automatic t_redirect_gap();
        train(64'h3000, 64'h5000, 1'b1);
        train(64'h3004, 64'h5100, 1'b1);
        train(64'h3008, 64'h5200, 1'b1);
        do_fetch(64'h3000, 1'b0, 1'b0, 1'b0, 64'd0, "R4 first");
        do_fetch(64'h3004, 1'b1, 1'b0, 1'b0, 64'd0, "R4 second");
        do_fetch(64'h3008, 1'b1, 1'b0, 1'b1, 64'h5200, "R4 third");
        idle();
    endtask

    task automatic t_alias_replace();
        train(64'h4010, 64'h6000, 1'b1);
        train(64'h5010, 64'h7000, 1'b1);
        do_fetch(64'h4008, 1'b0, 1'b0, 1'b0, 64'd0, "R10");
        do_fetch(64'h400C, 1'b1, 1'b0, 1'b0, 64'd0, "R10");
        do_fetch(64'h4010, 1'b1, 1'b0, 1'b0, 64'd0, "R10 old branch replaced");
        do_fetch(64'h5008, 1'b0, 1'b0, 1'b0, 64'd0, "R10");
        do_fetch(64'h500C, 1'b1, 1'b0, 1'b0, 64'd0, "R10");
        do_fetch(64'h5010, 1'b1, 1'b0, 1'b1, 64'h7000, "R10 new branch");
        idle();
        // differs from the fetch only in bit 63
        train(64'h8000_0000_0000_6020, 64'h9000, 1'b1);
        do_fetch(64'h6018, 1'b0, 1'b0, 1'b0, 64'd0, "R5");
        do_fetch(64'h601C, 1'b1, 1'b0, 1'b0, 64'd0, "R5");
        do_fetch(64'h6020, 1'b1, 1'b0, 1'b0, 64'd0, "R5 upper bit alias");
        idle();
        // low two bits of the update are ignored
        train(64'h7023, 64'h8001, 1'b1);
        do_fetch(64'h7018, 1'b0, 1'b0, 1'b0, 64'd0, "R5");
        do_fetch(64'h701C, 1'b1, 1'b0, 1'b0, 64'd0, "R5");
        do_fetch(64'h7020, 1'b1, 1'b0, 1'b1, 64'h8000, "R5 low bits ignored");
        idle();
    endtask

    task automatic t_flush();
        train(64'hA008, 64'hB000, 1'b1);
        do_fetch(64'hA000, 1'b0, 1'b0, 1'b0, 64'd0, "R6");
        do_fetch(64'hA004, 1'b1, 1'b0, 1'b0, 64'd0, "R6");
        do_fetch(64'hA008, 1'b1, 1'b1, 1'b0, 64'd0, "R6 flush suppresses");
        do_fetch(64'hA000, 1'b0, 1'b0, 1'b0, 64'd0, "R6");
        do_fetch(64'hA004, 1'b1, 1'b0, 1'b0, 64'd0, "R6");
        do_fetch(64'hA008, 1'b1, 1'b0, 1'b1, 64'hB000, "R6 entry kept");
        idle();
    endtask

    task automatic t_same_cycle();
        // fetch C100 reads index of C108 while C108 is written
        @(negedge clk);
        fetch_en = 1'b1; fetch_pc = 64'hC100; fetch_seq = 1'b0; flush = 1'b0;
        upd_en = 1'b1; upd_pc = 64'hC108; upd_tgt = 64'hD000; upd_taken = 1'b1;
        #1;
        chk("R7", {63'd0, pred_hit}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        upd_en = 1'b0; fetch_en = 1'b0;
        do_fetch(64'hC104, 1'b1, 1'b0, 1'b0, 64'd0, "R7");
        do_fetch(64'hC108, 1'b1, 1'b0, 1'b0, 64'd0, "R7 old contents read");
        do_fetch(64'hC100, 1'b0, 1'b0, 1'b0, 64'd0, "R7");
        do_fetch(64'hC104, 1'b1, 1'b0, 1'b0, 64'd0, "R7");
        do_fetch(64'hC108, 1'b1, 1'b0, 1'b1, 64'hD000, "R7 new contents later");
        idle();
    endtask

    task automatic t_stall();
        train(64'hE008, 64'hF000, 1'b1);
        do_fetch(64'hE000, 1'b0, 1'b0, 1'b0, 64'd0, "R8");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            fetch_en = 1'b0; fetch_pc = 64'hE008; fetch_seq = 1'b1;
            #1;
            chk("R8 idle", {63'd0, pred_hit}, 64'd0);
        end
        do_fetch(64'hE004, 1'b1, 1'b0, 1'b0, 64'd0, "R8");
        idle();
        idle();
        do_fetch(64'hE008, 1'b1, 1'b0, 1'b1, 64'hF000, "R8 after stalls");
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic_hit();
        t_not_taken();
        t_redirect_gap();
        t_alias_replace();
        t_flush();
        t_same_cycle();
        t_stall();
        repeat (2) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule